// File: doc/BRIEF.md
# Serial ADC Frame Capture

This block drives a 12-bit serial-output analog-to-digital converter from the FPGA side. It makes the serial clock by dividing the system clock, and it frames each conversion with an active-low chip select. It reads the converter's data line once per falling serial-clock edge. A frame is sixteen bits long. The first four bits are a header of zeros and are dropped. The next twelve bits, most significant first, form the result.

Every finished result goes into an eight-entry buffer, and a one-cycle valid pulse marks each write. A second module can read any entry at any time through its own address input. That read path is combinational and does not depend on the capture logic. A header bit that reads as one sets a sticky error flag.

All logic runs on the system clock. The serial clock is a registered output, and its edges are handled as enables inside that one clock domain.

Top module: `adc_frame_capture`

## Requirements
- R1: After reset, cs_n_o and sclk_o are high, wr_valid_o and hdr_err_o are low, and the first write goes to buffer address 0.
- R2: While cs_n_o is low, sclk_o toggles exactly every HALF_DIV system cycles. The first toggle is a fall, HALF_DIV cycles after cs_n_o falls.
- R3: Each low period of cs_n_o holds exactly 16 falling edges of sclk_o. Between frames, cs_n_o stays high for at least 2*HALF_DIV cycles, and sclk_o is high throughout that time.
- R4: The bits sampled at the first four falling edges of a frame never appear in the result.
- R5: The bits sampled at falling edges 5 to 16 form the 12-bit result, most significant bit first. Each bit is the value of sdata_i at the system edge where sclk_o goes low.
- R6: Each frame ends with one buffer write, marked by a single-cycle wr_valid_o pulse. During that pulse, wr_data_o carries the result and wr_addr_o carries the address written.
- R7: The write address advances by one per frame modulo 8. The ninth result overwrites address 0.
- R8: rd_data_o always equals the buffer entry at rd_addr_i, and reads never disturb capture.
- R9: hdr_err_o goes high when any header bit reads as 1. Only reset clears it, and the data of that frame is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_o | output | 1 | Serial clock to the converter, idle high |
| cs_n_o | output | 1 | Active-low chip select |
| sdata_i | input | 1 | Serial data from the converter |
| rd_addr_i | input | 3 | Buffer read address |
| rd_data_o | output | 12 | Buffer entry at rd_addr_i |
| wr_valid_o | output | 1 | One-cycle pulse per stored result |
| wr_addr_o | output | 3 | Address of the current write |
| wr_data_o | output | 12 | Result of the current write |
| hdr_err_o | output | 1 | Sticky header error flag |

## Verification
The bench models the converter bit by bit. It feeds directed words with all ones, all zeros and single set bits at each end of the result, then random words. If the design were off by one bit position, these words would show a shifted or truncated result. If it sampled on the wrong edge, they would show a neighbour's bit. The bench counts falling edges, half-period lengths and gap lengths on every frame, so a seventeenth edge or a short gap gets caught. A header error is injected in one late frame to prove that the flag stays low until then, stays high afterwards, and does not stop the result being stored. Forty frames wrap the write pointer five times, and random read addresses during capture catch any read that lags or overwrites the buffer.

// File: rtl/adc_frame_capture.sv
module adc_frame_capture #(
  parameter int HALF_DIV = 2,
  parameter int HDR_W    = 4,
  parameter int RES_W    = 12,
  parameter int DEPTH    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  output logic                     sclk_o,
  output logic                     cs_n_o,
  input  logic                     sdata_i,
  input  logic [$clog2(DEPTH)-1:0] rd_addr_i,
  output logic [RES_W-1:0]         rd_data_o,
  output logic                     wr_valid_o,
  output logic [$clog2(DEPTH)-1:0] wr_addr_o,
  output logic [RES_W-1:0]         wr_data_o,
  output logic                     hdr_err_o
);
  localparam int FRAME_W = HDR_W + RES_W;
  localparam int AW      = $clog2(DEPTH);
  localparam int DW      = $clog2(HALF_DIV + 1);
  localparam int BW      = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {S_GAP, S_RUN, S_TAIL} state_t;

  state_t           state;
  logic [DW-1:0]    dcnt;
  logic             gap_half;
  logic [BW-1:0]    bcnt;
  logic [RES_W-1:0] shreg;
  logic [AW-1:0]    wp;
  logic [RES_W-1:0] mem [DEPTH];

  wire tick = (dcnt == DW'(HALF_DIV - 1));
  wire fall = (state == S_RUN) && tick && sclk_o;
  wire in_hdr = (bcnt < BW'(HDR_W));
  wire last = (bcnt == BW'(FRAME_W - 1));
  wire [RES_W-1:0] next_sh = {shreg[RES_W-2:0], sdata_i};

  assign rd_data_o = mem[rd_addr_i];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dcnt <= '0;
    else dcnt <= tick ? '0 : dcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_GAP;
      sclk_o   <= 1'b1;
      cs_n_o   <= 1'b1;
      gap_half <= 1'b0;
      bcnt     <= '0;
    end else if (tick) begin
      case (state)
        S_GAP: begin
          gap_half <= ~gap_half;
          if (gap_half) begin
            state  <= S_RUN;
            cs_n_o <= 1'b0;
            bcnt   <= '0;
          end
        end
        S_RUN: begin
          sclk_o <= ~sclk_o;
          if (sclk_o) begin
            bcnt <= bcnt + 1'b1;
            if (last) state <= S_TAIL;
          end
        end
        default: begin
          sclk_o   <= 1'b1;
          cs_n_o   <= 1'b1;
          gap_half <= 1'b0;
          state    <= S_GAP;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      hdr_err_o  <= 1'b0;
      wp         <= '0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      if (fall) begin
        if (in_hdr) begin
          if (sdata_i) hdr_err_o <= 1'b1;
        end else begin
          shreg <= next_sh;
        end
        if (last) begin
          wr_valid_o <= 1'b1;
          wr_addr_o  <= wp;
          wr_data_o  <= next_sh;
          wp         <= wp + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (fall && last) mem[wp] <= next_sh;

  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);
  p_fall_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> !cs_n_o);
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);
  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (wp == AW'(wr_addr_o + 1'b1)));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err_o |=> hdr_err_o);
  p_write_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && rd_addr_i == wr_addr_o) |-> (rd_data_o == wr_data_o));
endmodule

// File: tb/adc_frame_capture_tb.sv
module adc_frame_capture_tb_top;
  localparam int HALF = 2;
  localparam int NF   = 40;
  localparam int ERRF = 20;

  logic clk = 1'b0, rst_n = 1'b0, sdata = 1'b0;
  logic [2:0] rd_addr = '0;
  logic sclk, cs_n, wr_valid, hdr_err;
  logic [2:0] wr_addr;
  logic [11:0] rd_data, wr_data;

  always #5 clk = ~clk;

  adc_frame_capture #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_o(sclk), .cs_n_o(cs_n), .sdata_i(sdata),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .wr_valid_o(wr_valid),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .hdr_err_o(hdr_err));

  int checks = 0, fails = 0;
  logic [15:0] word [NF];
  logic [11:0] exp_mem [8];
  logic        written [8];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int k, input int r);
    logic [11:0] d;
    case (k)
      0: d = 12'hFFF; 1: d = 12'h000; 2: d = 12'h800; 3: d = 12'h001; 4: d = 12'hA55;
      default: d = r[11:0];
    endcase
    return {(k == ERRF) ? 4'b0010 : 4'b0000, d};
  endfunction

  int fk = 0, idx = 0, nwr = 0, falls = 0, hcnt = 0, gcnt = 0, cyc = 0;
  bit psclk = 1'b1, pcs = 1'b1, pvalid = 1'b0, done = 1'b0;

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < NF; k++) word[k] = mk(k, $urandom);
    for (int a = 0; a < 8; a++) written[a] = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n && sclk && !wr_valid && !hdr_err, "R1 reset outputs",
        {cs_n, sclk, wr_valid, hdr_err}, 4'b1100);
    rst_n = 1'b1;
    wait (done);
    repeat (4) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #1;
      chk(rd_data == exp_mem[a], "R7 R8 final readback after wrap", rd_data, exp_mem[a]);
    end
    chk(hdr_err == 1'b1, "R9 flag still set at end", hdr_err, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(negedge clk) if (rst_n && !done) begin
    cyc++;
    if (cyc > 100000) begin
      chk(1'b0, "watchdog", cyc, 0);
      done = 1'b1;
    end
    if (pvalid) chk(!wr_valid, "R6 pulse one cycle", wr_valid, 0);
    if (wr_valid) begin
      chk(wr_data == word[fk][11:0], "R4 R5 result", wr_data, word[fk][11:0]);
      chk(wr_addr == 3'(nwr % 8), "R7 write address", wr_addr, nwr % 8);
      if (nwr == 0) chk(wr_addr == 3'd0, "R1 first address", wr_addr, 0);
      chk(hdr_err == (fk >= ERRF), "R9 sticky header flag", hdr_err, fk >= ERRF);
      exp_mem[nwr % 8] = word[fk][11:0];
      written[nwr % 8] = 1'b1;
      nwr++;
    end
    if (written[rd_addr])
      chk(rd_data == exp_mem[rd_addr], "R8 live read", rd_data, exp_mem[rd_addr]);
    if (pcs && !cs_n) begin
      chk(gcnt >= 2 * HALF, "R3 gap length", gcnt, 2 * HALF);
      idx = 0; falls = 0; hcnt = 0;
    end else if (!pcs && cs_n) begin
      chk(falls == 16, "R3 falls per frame", falls, 16);
      gcnt = 0;
      fk++;
      if (fk >= NF) done = 1'b1;
    end else if (!cs_n) begin
      hcnt++;
      if (sclk != psclk) begin
        chk(hcnt == HALF, "R2 half period", hcnt, HALF);
        hcnt = 0;
        if (!sclk) falls++;
        else idx++;
      end
    end
    if (cs_n) begin
      gcnt++;
      chk(sclk, "R3 sclk high between frames", sclk, 1);
    end
    sdata = (fk < NF && idx < 16) ? word[fk][15 - idx] : 1'b0;
    pvalid = wr_valid; psclk = sclk; pcs = cs_n;
    rd_addr = 3'($urandom_range(0, 7));
  end
endmodule